// File: doc/BRIEF.md
# Reorder Buffer with In-Order Retirement

This block keeps micro-ops in a circular buffer from the moment they are dispatched until they are committed. Dispatch allocates one entry per cycle at the tail and receives the entry tag. Execution units return results against that tag in any order. An entry is therefore either still waiting for its result or finished but not yet committed.

Each cycle the retirement logic looks at the oldest entries, starting at the head. It commits up to three finished entries, always oldest first, and writes their values into an eight-entry architectural register file. An entry that finished with an exception or a mispredicted branch never commits. When that entry becomes the oldest, the block raises a flush and discards every entry. The register file has a combinational read port, so its committed state can be observed.

Top module: `rob_top`

## Requirements
- R1: Reset state. While reset is high and in the first cycle after it, `alloc_ready` is 1, `alloc_tag` is 0, `ret_valid` is 0 and `flush` is 0. Every architectural register reads 0.
- R2: Tag order. `alloc_tag` shows the tag the next allocation will receive. An allocation happens when `alloc_valid` and `alloc_ready` are both high at a rising edge. Tags are issued in the sequence 0, 1, …, 39 and then wrap to 0.
- R3: Full buffer. After 40 entries are held, `alloc_ready` is 0. An `alloc_valid` pulse in that state changes neither `alloc_tag` nor the buffer contents.
- R4: Out-of-order completion. A completion (`cmp_valid`, `cmp_tag`, `cmp_value`, `cmp_fault`) marks the entry with that tag as finished and stores its value, in any order relative to other entries. A completion that names a free entry is ignored: a later allocation of that tag still waits for its own result.
- R5: Retirement lanes. In the same cycle that entries are retired, lane k (k = 0..2) shows the k-th oldest retiring entry. The lane carries `ret_valid[k]`, `ret_wen[k]`, `ret_dst[3k+2:3k]` and `ret_value[32k+31:32k]`. Retired entries are freed at the next rising edge.
- R6: Stall on incomplete entry. Retirement stops at the oldest entry that has not finished. No younger entry retires past it, even if the younger entry is finished.
- R7: Register write. At the edge that ends a retirement cycle, each retiring lane with its write enable set writes its value to its destination register. If several lanes in that cycle name the same register, the youngest lane wins. A lane with its write enable clear writes nothing.
- R8: Flush. When the oldest entry is finished with its fault flag set, `flush` is 1 for that cycle and nothing retires. At the next edge every entry is discarded. Afterwards `alloc_tag` is 0, `alloc_ready` is 1, and allocations and completions offered during the flush cycle have no effect.
- R9: Fault boundary. A faulted entry that is not the oldest blocks the lanes behind it. Older finished entries ahead of it still retire in that cycle.
- R10: Occupancy. When an allocation and a retirement happen in the same cycle, the occupancy count is updated correctly, including when head or tail wraps from 39 to 0. `alloc_ready` falls exactly when 40 entries are held.
- R11: Register read. `rd_data` shows the architectural register selected by `rd_idx` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| alloc_valid | input | 1 | Dispatch requests an entry |
| alloc_dst | input | 3 | Destination register of the new micro-op |
| alloc_wen | input | 1 | New micro-op writes a register |
| alloc_ready | output | 1 | An entry can be taken this cycle |
| alloc_tag | output | 6 | Tag given to the next allocation |
| cmp_valid | input | 1 | Execution result is presented |
| cmp_tag | input | 6 | Entry the result belongs to |
| cmp_value | input | 32 | Result value |
| cmp_fault | input | 1 | Result carries an exception or misprediction |
| ret_valid | output | 3 | Per lane: an entry retires this cycle |
| ret_wen | output | 3 | Per lane: retiring entry writes a register |
| ret_dst | output | 9 | Per lane: destination register, 3 bits each |
| ret_value | output | 96 | Per lane: committed value, 32 bits each |
| flush | output | 1 | Oldest entry faulted; whole buffer is discarded at the next edge |
| rd_idx | input | 3 | Architectural register select |
| rd_data | output | 32 | Selected architectural register value |

## Verification
Completion in strict reverse order keeps every younger entry waiting behind an unfinished head. This shows the head stall apart from any per-entry logic, and when the head finally finishes it releases a burst that must come out three per cycle. A fault placed in the middle of a group shows that older lanes still commit in the fault cycle and the flush comes one cycle later. Three writes to one register in a single cycle tell whether the youngest lane wins. A long random sweep keeps allocation and retirement overlapping across many wraps of the pointers, and compares every lane and the register file against a sequential model every cycle.

// File: rtl/rob_pkg.sv
package rob_pkg;
    parameter int ROB_DEPTH = 40;
    parameter int RET_W     = 3;
    parameter int ARCH_REGS = 8;
    parameter int DATA_W    = 32;

    localparam int TAG_W = $clog2(ROB_DEPTH);
    localparam int REG_W = $clog2(ARCH_REGS);
    localparam int CNT_W = $clog2(ROB_DEPTH + 1);
    localparam int NUM_W = $clog2(RET_W + 1);

    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [REG_W-1:0]  reg_t;
    typedef logic [DATA_W-1:0] data_t;
    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [NUM_W-1:0]  num_t;

    typedef struct packed {
        logic  busy;
        logic  done;
        logic  fault;
        logic  wen;
        reg_t  dst;
        data_t value;
    } entry_t;

    typedef struct packed {
        logic  vld;
        logic  wen;
        reg_t  dst;
        data_t value;
    } lane_t;

    function automatic tag_t tag_add(tag_t t, int unsigned k);
        int unsigned s;
        s = int'(t) + k;
        if (s >= ROB_DEPTH) s = s - ROB_DEPTH;
        return tag_t'(s);
    endfunction
endpackage

// File: rtl/rob_ptrs.sv
module rob_ptrs
    import rob_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic alloc_fire,
    input  num_t ret_num,
    input  logic flush,
    output tag_t head,
    output tag_t tail,
    output cnt_t count
);
    always_ff @(posedge clk) begin
        if (rst || flush) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            head  <= tag_add(head, int'(ret_num));
            if (alloc_fire) tail <= tag_add(tail, 1);
            count <= count + cnt_t'(alloc_fire) - cnt_t'(ret_num);
        end
    end

    // R10
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        count <= cnt_t'(ROB_DEPTH));

    // R8
    flush_clears_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> (count == '0) && (head == tail) && (head == '0));
endmodule

// File: rtl/rob_retire_sel.sv
module rob_retire_sel
    import rob_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  entry_t ents [ROB_DEPTH],
    input  tag_t   head,
    input  cnt_t   count,
    output lane_t  lanes [RET_W],
    output num_t   ret_num,
    output logic   flush_req
);
    always_comb begin
        logic   stop;
        int     n;
        entry_t e;
        stop = 1'b0;
        n    = 0;
        flush_req = ents[head].busy && ents[head].done && ents[head].fault;
        for (int k = 0; k < RET_W; k++) begin
            e = ents[tag_add(head, k)];
            lanes[k] = '0;
            if (!stop && (k < int'(count)) && e.busy && e.done && !e.fault) begin
                lanes[k].vld   = 1'b1;
                lanes[k].wen   = e.wen;
                lanes[k].dst   = e.dst;
                lanes[k].value = e.value;
                n = n + 1;
            end else begin
                stop = 1'b1;
            end
        end
        ret_num = num_t'(n);
    end

    generate
        for (genvar g = 1; g < RET_W; g++) begin : g_order
            // R6
            lane_order_chk: assert property (@(posedge clk) disable iff (rst)
                lanes[g].vld |-> lanes[g-1].vld);
        end
    endgenerate

    // R8
    flush_no_retire_chk: assert property (@(posedge clk) disable iff (rst)
        flush_req |-> (ret_num == '0));
endmodule

// File: rtl/rob_arf.sv
module rob_arf
    import rob_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  lane_t lanes [RET_W],
    input  reg_t  rd_idx,
    output data_t rd_data
);
    data_t regs [ARCH_REGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < ARCH_REGS; r++) regs[r] <= '0;
        end else begin
            // later lanes overwrite earlier ones: youngest wins
            for (int k = 0; k < RET_W; k++)
                if (lanes[k].vld && lanes[k].wen) regs[lanes[k].dst] <= lanes[k].value;
        end
    end

    assign rd_data = regs[rd_idx];
endmodule

// File: rtl/rob_top.sv
module rob_top
    import rob_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    alloc_valid,
    input  logic [REG_W-1:0]        alloc_dst,
    input  logic                    alloc_wen,
    output logic                    alloc_ready,
    output logic [TAG_W-1:0]        alloc_tag,
    input  logic                    cmp_valid,
    input  logic [TAG_W-1:0]        cmp_tag,
    input  logic [DATA_W-1:0]       cmp_value,
    input  logic                    cmp_fault,
    output logic [RET_W-1:0]        ret_valid,
    output logic [RET_W-1:0]        ret_wen,
    output logic [RET_W*REG_W-1:0]  ret_dst,
    output logic [RET_W*DATA_W-1:0] ret_value,
    output logic                    flush,
    input  logic [REG_W-1:0]        rd_idx,
    output logic [DATA_W-1:0]       rd_data
);
    entry_t ents [ROB_DEPTH];
    lane_t  lanes [RET_W];
    tag_t   head, tail;
    cnt_t   count;
    num_t   ret_num;
    logic   flush_req;
    logic   alloc_fire;
    logic   cmp_hit;

    rob_ptrs u_ptrs (
        .clk(clk), .rst(rst), .alloc_fire(alloc_fire), .ret_num(ret_num),
        .flush(flush_req), .head(head), .tail(tail), .count(count)
    );

    rob_retire_sel u_sel (
        .clk(clk), .rst(rst), .ents(ents), .head(head), .count(count),
        .lanes(lanes), .ret_num(ret_num), .flush_req(flush_req)
    );

    rob_arf u_arf (
        .clk(clk), .rst(rst), .lanes(lanes), .rd_idx(rd_idx), .rd_data(rd_data)
    );

    assign alloc_ready = (count != cnt_t'(ROB_DEPTH)) && !flush_req;
    assign alloc_fire  = alloc_valid && alloc_ready;
    assign alloc_tag   = tail;
    assign flush       = flush_req;
    assign cmp_hit     = cmp_valid && (int'(cmp_tag) < ROB_DEPTH)
                         && ents[cmp_tag].busy && !ents[cmp_tag].done;

    generate
        for (genvar g = 0; g < RET_W; g++) begin : g_lane_out
            assign ret_valid[g]                  = lanes[g].vld;
            assign ret_wen[g]                    = lanes[g].wen;
            assign ret_dst[g*REG_W +: REG_W]     = lanes[g].dst;
            assign ret_value[g*DATA_W +: DATA_W] = lanes[g].value;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || flush_req) begin
            for (int i = 0; i < ROB_DEPTH; i++) ents[i] <= '0;
        end else begin
            for (int k = 0; k < RET_W; k++)
                if (lanes[k].vld) begin
                    ents[tag_add(head, k)].busy <= 1'b0;
                    ents[tag_add(head, k)].done <= 1'b0;
                end
            if (cmp_hit) begin
                ents[cmp_tag].done  <= 1'b1;
                ents[cmp_tag].fault <= cmp_fault;
                ents[cmp_tag].value <= cmp_value;
            end
            if (alloc_fire)
                ents[tail] <= '{busy: 1'b1, done: 1'b0, fault: 1'b0,
                                wen: alloc_wen, dst: alloc_dst, value: '0};
        end
    end

    // R3
    alloc_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
        (alloc_valid && alloc_ready) |=> (count != '0));

    // R10
    retire_within_count_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(ret_valid) <= int'(count));
endmodule

// File: tb/test_rob_top.sv
module test_rob_top;
    import rob_pkg::*;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic alloc_valid = 0, alloc_wen = 0;
    logic [REG_W-1:0] alloc_dst = '0;
    logic alloc_ready;
    logic [TAG_W-1:0] alloc_tag;
    logic cmp_valid = 0, cmp_fault = 0;
    logic [TAG_W-1:0] cmp_tag = '0;
    logic [DATA_W-1:0] cmp_value = '0;
    logic [RET_W-1:0] ret_valid, ret_wen;
    logic [RET_W*REG_W-1:0] ret_dst;
    logic [RET_W*DATA_W-1:0] ret_value;
    logic flush;
    logic [REG_W-1:0] rd_idx = '0;
    logic [DATA_W-1:0] rd_data;

    int checks = 0, failures = 0;
    bit finished = 0;

    // sequential reference model
    int m_head = 0, m_tail = 0, m_cnt = 0;
    bit m_busy [ROB_DEPTH], m_done [ROB_DEPTH], m_fault [ROB_DEPTH], m_wen [ROB_DEPTH];
    int m_dst [ROB_DEPTH];
    logic [DATA_W-1:0] m_val [ROB_DEPTH];
    logic [DATA_W-1:0] ref_rf [ARCH_REGS];

    rob_top i_rob_top (
        .clk(clk), .rst(rst), .alloc_valid(alloc_valid), .alloc_dst(alloc_dst),
        .alloc_wen(alloc_wen), .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
        .cmp_valid(cmp_valid), .cmp_tag(cmp_tag), .cmp_value(cmp_value),
        .cmp_fault(cmp_fault), .ret_valid(ret_valid), .ret_wen(ret_wen),
        .ret_dst(ret_dst), .ret_value(ret_value), .flush(flush),
        .rd_idx(rd_idx), .rd_data(rd_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < ROB_DEPTH; i++) begin
            m_busy[i] = 0; m_done[i] = 0; m_fault[i] = 0;
        end
        m_head = 0; m_tail = 0; m_cnt = 0;
    endtask

    task automatic set_idle();
        alloc_valid = 0; cmp_valid = 0; cmp_fault = 0;
    endtask

    // one cycle: compare outputs against the model, then advance both
    task automatic step();
        bit flush_e, ready_e, stop, lane_e;
        int idx, nret;
        #1;
        flush_e = (m_cnt > 0) && m_done[m_head] && m_fault[m_head];
        ready_e = (m_cnt < ROB_DEPTH) && !flush_e;
        chk(alloc_ready == ready_e, "R3 R10", "alloc_ready", alloc_ready, ready_e);
        chk(int'(alloc_tag) == m_tail, "R2", "alloc_tag", alloc_tag, m_tail);
        chk(flush == flush_e, "R8", "flush", flush, flush_e);
        chk(rd_data == ref_rf[rd_idx], "R11", "rd_data", rd_data, ref_rf[rd_idx]);
        stop = 0; nret = 0;
        for (int k = 0; k < RET_W; k++) begin
            idx = (m_head + k) % ROB_DEPTH;
            lane_e = !stop && !flush_e && (k < m_cnt) && m_done[idx] && !m_fault[idx];
            if (lane_e) nret++; else stop = 1;
            chk(ret_valid[k] == lane_e, "R5 R6 R9", "ret_valid lane", ret_valid[k], lane_e);
            if (lane_e) begin
                chk(int'(ret_dst[k*REG_W +: REG_W]) == m_dst[idx], "R5", "ret_dst",
                    ret_dst[k*REG_W +: REG_W], m_dst[idx]);
                chk(ret_wen[k] == m_wen[idx], "R5", "ret_wen", ret_wen[k], m_wen[idx]);
                chk(ret_value[k*DATA_W +: DATA_W] == m_val[idx], "R5", "ret_value",
                    ret_value[k*DATA_W +: DATA_W], m_val[idx]);
            end
        end
        @(posedge clk);
        if (flush_e) begin
            model_clear();
        end else begin
            for (int k = 0; k < nret; k++) begin
                idx = (m_head + k) % ROB_DEPTH;
                if (m_wen[idx]) ref_rf[m_dst[idx]] = m_val[idx];
                m_busy[idx] = 0; m_done[idx] = 0;
            end
            m_head = (m_head + nret) % ROB_DEPTH;
            m_cnt  = m_cnt - nret;
            if (cmp_valid && int'(cmp_tag) < ROB_DEPTH && m_busy[cmp_tag] && !m_done[cmp_tag]) begin
                m_done[cmp_tag] = 1; m_fault[cmp_tag] = cmp_fault; m_val[cmp_tag] = cmp_value;
            end
            if (alloc_valid && ready_e) begin
                m_busy[m_tail] = 1; m_done[m_tail] = 0; m_fault[m_tail] = 0;
                m_wen[m_tail] = alloc_wen; m_dst[m_tail] = int'(alloc_dst);
                m_tail = (m_tail + 1) % ROB_DEPTH;
                m_cnt++;
            end
        end
        @(negedge clk);
        rd_idx = rd_idx + 1'b1;
    endtask

    task automatic alloc_one(input int dst, input bit wen);
        set_idle();
        alloc_valid = 1; alloc_dst = REG_W'(dst); alloc_wen = wen;
        step();
        set_idle();
    endtask

    task automatic complete_one(input int tag, input logic [DATA_W-1:0] v, input bit f);
        set_idle();
        cmp_valid = 1; cmp_tag = TAG_W'(tag); cmp_value = v; cmp_fault = f;
        step();
        set_idle();
    endtask

    task automatic drain();
        for (int n = 0; n < 400 && m_cnt > 0; n++) begin
            int pick;
            pick = -1;
            for (int j = 0; j < ROB_DEPTH; j++)
                if (pick < 0 && m_busy[(m_head + j) % ROB_DEPTH] && !m_done[(m_head + j) % ROB_DEPTH])
                    pick = (m_head + j) % ROB_DEPTH;
            if (pick >= 0) complete_one(pick, $urandom, 0);
            else begin set_idle(); step(); end
        end
    endtask

    initial begin
        repeat (CLK_PERIOD * 20000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int base;
        logic [DATA_W-1:0] v3;
        model_clear();
        for (int r = 0; r < ARCH_REGS; r++) ref_rf[r] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #1;
        // R1 reset state
        chk(alloc_ready == 1, "R1", "alloc_ready", alloc_ready, 1);
        chk(alloc_tag == 0, "R1", "alloc_tag", alloc_tag, 0);
        chk(ret_valid == 0, "R1", "ret_valid", ret_valid, 0);
        chk(flush == 0, "R1", "flush", flush, 0);
        for (int r = 0; r < ARCH_REGS; r++) begin
            rd_idx = REG_W'(r); #1;
            chk(rd_data == 0, "R1", "reg after reset", rd_data, 0);
        end

        // R4: completion to a free entry is ignored
        complete_one(5, 32'hDEAD_0005, 0);
        for (int i = 0; i < 6; i++) alloc_one(i, 1);
        repeat (3) step();
        chk(ret_valid == 0, "R4", "no retire after stale completion", ret_valid, 0);
        // R6: reverse-order completion stalls behind the head
        for (int t = 5; t >= 1; t--) complete_one(t, 32'h1000 + t, 0);
        #1; chk(ret_valid == 0, "R6", "stall behind unfinished head", ret_valid, 0);
        complete_one(0, 32'h1000, 0);
        #1; chk(ret_valid == 3'b111, "R5", "three lanes retire", ret_valid, 3'b111);
        repeat (3) step();

        // R3: fill all 40 entries (tail wraps from 39 to 0)
        for (int i = 0; i < ROB_DEPTH; i++) alloc_one(i % ARCH_REGS, (i % 3) != 0);
        #1;
        chk(alloc_ready == 0, "R3", "full refuses", alloc_ready, 0);
        base = int'(alloc_tag);
        alloc_valid = 1; step(); step(); set_idle(); #1;
        chk(int'(alloc_tag) == base, "R3", "tag unchanged when full", alloc_tag, base);
        for (int j = ROB_DEPTH - 1; j >= 0; j--)
            complete_one((m_head + j) % ROB_DEPTH, $urandom, 0);
        drain();

        // R7: three writes to one register in one cycle, plus a non-writing lane
        base = m_tail;
        alloc_one(5, 1); alloc_one(5, 1); alloc_one(5, 1); alloc_one(6, 0);
        complete_one((base + 3) % ROB_DEPTH, 32'h6666_0000, 0);
        complete_one((base + 2) % ROB_DEPTH, 32'h5555_0003, 0);
        complete_one((base + 1) % ROB_DEPTH, 32'h5555_0002, 0);
        v3 = 32'h5555_0001;
        complete_one(base, v3, 0);
        step(); step();
        rd_idx = 3'd5; #1;
        chk(rd_data == 32'h5555_0003, "R7", "youngest lane wins", rd_data, 32'h5555_0003);
        rd_idx = 3'd6; #1;
        chk(rd_data == ref_rf[6], "R7", "wen clear writes nothing", rd_data, ref_rf[6]);

        // R8 / R9: fault in the middle of a group
        base = m_tail;
        for (int i = 0; i < 5; i++) alloc_one(i + 1, 1);
        complete_one((base + 2) % ROB_DEPTH, 32'hBAD, 1);
        complete_one((base + 3) % ROB_DEPTH, 32'h33, 0);
        complete_one((base + 4) % ROB_DEPTH, 32'h44, 0);
        complete_one((base + 1) % ROB_DEPTH, 32'h11, 0);
        complete_one(base, 32'h10, 0);
        #1;
        chk(ret_valid == 3'b011, "R9", "older lanes retire before fault", ret_valid, 3'b011);
        chk(flush == 0, "R9", "no flush yet", flush, 0);
        step();
        #1;
        chk(flush == 1, "R8", "flush at head fault", flush, 1);
        chk(ret_valid == 0, "R8", "nothing retires on flush", ret_valid, 0);
        alloc_valid = 1; cmp_valid = 1; cmp_tag = TAG_W'(base);
        step(); set_idle(); #1;
        chk(alloc_tag == 0, "R8", "tag restarts", alloc_tag, 0);
        chk(alloc_ready == 1, "R8", "ready after flush", alloc_ready, 1);
        step();
        chk(ret_valid == 0, "R8", "discarded entries stay gone", ret_valid, 0);

        // R10: random overlap of allocation, completion and retirement
        for (int c = 0; c < 3000; c++) begin
            int pick, st;
            set_idle();
            alloc_valid = ($urandom % 4) != 0;
            alloc_dst = REG_W'($urandom); alloc_wen = $urandom % 2;
            if (($urandom % 4) != 0) begin
                pick = -1; st = $urandom % ROB_DEPTH;
                for (int j = 0; j < ROB_DEPTH; j++)
                    if (pick < 0 && m_busy[(st + j) % ROB_DEPTH] && !m_done[(st + j) % ROB_DEPTH])
                        pick = (st + j) % ROB_DEPTH;
                if (pick >= 0) begin
                    cmp_valid = 1; cmp_tag = TAG_W'(pick); cmp_value = $urandom;
                    cmp_fault = ($urandom % 48) == 0;
                end
            end
            step();
        end
        set_idle();
        drain();
        step();
        chk(m_cnt == 0 && alloc_ready == 1, "R10", "buffer drains", alloc_ready, 1);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule